// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 1 Kbit serial EEPROM that sits behind a three-wire interface. The interface has a chip select, a serial clock, a serial data input and a serial data output. The storage is held in registers. An organization input sets how it is addressed: as 64 words of 16 bits, or as 128 bytes. The block decodes seven instructions: read, write, erase, erase-all, write-all, write-enable and write-disable.

All interface pins are sampled on the system clock. Edges of the serial clock and of chip select are found by comparing each sampled value with the one from the cycle before. Each program instruction arms a self-timed cycle, which starts when chip select falls and is counted on the system clock. While that cycle runs, the data output is held low. When it ends, the output returns high and the memory holds the new contents. Reads stream one word after another for as long as the serial clock keeps running.

Top module: `sprom_3w`

## Requirements
- R1: With `org_i` high, the array is 64 words of 16 bits, addressed by a 6-bit address field and transferred MSB first.
- R2: With `org_i` low, the array is 128 bytes with a 7-bit address field. Byte address bit 0 selects the upper half (1) or the lower half (0) of the 16-bit word at address bits 6..1.
- R3: After reset every array bit is 1, the block is write-disabled and `do_o` is high.
- R4: A frame begins at the first 1 on `di_i` sampled on a rising `sck_i` edge while `cs_i` is high. Leading zeros are ignored. The 2-bit opcode follows: 10 read, 01 write, 11 erase, 00 extended. For the extended opcode, the two most significant address bits select the command: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all. After a complete non-read frame, further bits are ignored until `cs_i` falls.
- R5: `di_i` is sampled on rising `sck_i` edges. After the last address bit of a read, `do_o` gives one 0 dummy bit. Each following rising edge then shifts out the next data bit, MSB first.
- R6: After the last bit of a word, a read goes on with the next address, without a new address. The address wraps from the top of the array to 0.
- R7: While the block is write-disabled, write, erase, erase-all and write-all leave the memory unchanged and start no program cycle.
- R8: A fully shifted program frame starts the program cycle when `cs_i` falls. `do_o` is low for PROG_CYCLES system clocks and then goes high. A frame cut short by `cs_i` falling starts nothing.
- R9: A word write replaces the whole target word with the new data, whatever the word held before.
- R10: Erase sets every bit of the addressed word (or byte) to 1.
- R11: Erase-all sets every bit of the array to 1.
- R12: Write-all writes the shifted data to every word. In byte mode both halves of every word receive the byte.
- R13: Frames sent while a program cycle runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data input |
| org_i | input | 1 | Organization: 1 selects 16-bit words, 0 selects bytes. Tie high when unused, as a pulled-up pin would read |
| do_o | output | 1 | Serial data output and ready (1) or busy (0) status |

## Verification
An input pin is registered once and then compared with the value from the cycle before. A new `do_o` bit therefore appears two system clocks after the `sck_i` rise that causes it. The bench holds each serial clock phase for four system clocks and samples `do_o` at the end of the high phase, well after it settles. Busy starts two clocks after `cs_i` falls and lasts PROG_CYCLES clocks. The bench checks for low at the second and at the PROG_CYCLES+1-th falling clock edge after the fall, and for high at the next one. Every write, erase and ignored command is then confirmed by a serial read-back against a model kept in the bench.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE} dec_state_e;
  typedef enum logic [2:0] {PG_NONE, PG_WRITE, PG_ERASE, PG_ERAL, PG_WRAL} prog_op_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_WEN  = 2'b11;
  localparam logic [1:0] EXT_WDS  = 2'b00;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_WRAL = 2'b01;
endpackage

// File: rtl/sprom_decoder.sv
module sprom_decoder
  import sprom_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sck_rise_i,
  input  logic              cs_fall_i,
  input  logic              di_i,
  input  logic              org_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              dout_o,
  output logic              start_o,
  output prog_op_e          op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int BYTE_W = WORD_W / 2;

  dec_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  prog_op_e          pend_q;
  logic              wen_q;

  logic [CNT_W-1:0]  aw_c, dw_c;
  logic [ADDR_W-1:0] addr_nx, addr_inc;
  logic [1:0]        sub_c;

  always_comb begin
    aw_c     = org_i ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
    dw_c     = org_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
    addr_nx  = {addr_q[ADDR_W-2:0], di_i};
    sub_c    = org_i ? addr_nx[ADDR_W-2 -: 2] : addr_nx[ADDR_W-1 -: 2];
    addr_inc = org_i ? {1'b0, addr_q[ADDR_W-2:0] + (ADDR_W-1)'(1)} : addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      pend_q  <= PG_NONE;
      wen_q   <= 1'b0;
    end else if (!cs_i || busy_i) begin
      state_q <= ST_IDLE;
      pend_q  <= PG_NONE;
    end else if (sck_rise_i) begin
      unique case (state_q)
        ST_IDLE: if (di_i) begin
          state_q <= ST_OPC;
          cnt_q   <= '0;
          addr_q  <= '0;
          pend_q  <= PG_NONE;
        end
        ST_OPC: begin
          opc_q <= {opc_q[0], di_i};
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_ADDR: begin
          addr_q <= addr_nx;
          if (cnt_q == aw_c - CNT_W'(1)) begin
            cnt_q <= '0;
            unique case (opc_q)
              OPC_READ:  begin state_q <= ST_READ; cnt_q <= dw_c; end
              OPC_WRITE: state_q <= ST_DATA;
              OPC_ERASE: begin state_q <= ST_DONE; pend_q <= PG_ERASE; end
              default: unique case (sub_c)
                EXT_WEN:  begin state_q <= ST_DONE; wen_q <= 1'b1; end
                EXT_WDS:  begin state_q <= ST_DONE; wen_q <= 1'b0; end
                EXT_ERAL: begin state_q <= ST_DONE; pend_q <= PG_ERAL; end
                default:  state_q <= ST_DATA;
              endcase
            endcase
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_DATA: begin
          data_q <= {data_q[WORD_W-2:0], di_i};
          if (cnt_q == dw_c - CNT_W'(1)) begin
            state_q <= ST_DONE;
            pend_q  <= (opc_q == OPC_WRITE) ? PG_WRITE : PG_WRAL;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_READ: begin
          if (cnt_q == '0) begin
            addr_q <= addr_inc;
            cnt_q  <= dw_c - CNT_W'(1);
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign dout_o    = (state_q != ST_READ) ? 1'b1 :
                     (cnt_q == dw_c) ? 1'b0 : rd_word_i[cnt_q[IDX_W-1:0]];
  assign start_o   = cs_fall_i && !busy_i && wen_q && (state_q == ST_DONE) && (pend_q != PG_NONE);
  assign op_o      = pend_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign rd_addr_o = addr_q;

  AST_IDLE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (state_q == ST_IDLE)); // R13
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && cs_i && !busy_i) |=> (state_q == ST_DONE)); // R4
endmodule

// File: rtl/sprom_prog_ctl.sv
module sprom_prog_ctl
  import sprom_pkg::*;
#(
  parameter int PROG_CYCLES = 2000,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  prog_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  output logic              commit_o,
  output prog_op_e          op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      op_o   <= PG_NONE;
      addr_o <= '0;
      data_o <= '0;
    end else if (start_i) begin
      cnt_q  <= CW'(PROG_CYCLES);
      op_o   <= op_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1));

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R8
  AST_COMMIT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o); // R8
endmodule

// File: rtl/sprom_array.sv
module sprom_array
  import sprom_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              org_i,
  input  logic              commit_i,
  input  prog_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int WI_W   = ADDR_W - 1;

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WI_W-1:0]   wi_c, ri_c;
  logic [WORD_W-1:0] fill_c, rw_c;

  // byte mode: address bit 0 picks the half, upper bits pick the word
  assign wi_c   = org_i ? addr_i[WI_W-1:0] : addr_i[ADDR_W-1:1];
  assign ri_c   = org_i ? rd_addr_i[WI_W-1:0] : rd_addr_i[ADDR_W-1:1];
  assign fill_c = org_i ? data_i : {2{data_i[BYTE_W-1:0]}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      unique case (op_i)
        PG_WRITE: begin
          if (org_i) mem_q[wi_c] <= data_i;
          else if (addr_i[0]) mem_q[wi_c][WORD_W-1 -: BYTE_W] <= data_i[BYTE_W-1:0];
          else mem_q[wi_c][BYTE_W-1:0] <= data_i[BYTE_W-1:0];
        end
        PG_ERASE: begin
          if (org_i) mem_q[wi_c] <= '1;
          else if (addr_i[0]) mem_q[wi_c][WORD_W-1 -: BYTE_W] <= '1;
          else mem_q[wi_c][BYTE_W-1:0] <= '1;
        end
        PG_ERAL: for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        PG_WRAL: for (int i = 0; i < WORDS; i++) mem_q[i] <= fill_c;
        default: ;
      endcase
    end
  end

  assign rw_c      = mem_q[ri_c];
  assign rd_word_o = org_i ? rw_c :
                     {{BYTE_W{1'b0}}, rd_addr_i[0] ? rw_c[WORD_W-1 -: BYTE_W] : rw_c[BYTE_W-1:0]};

  AST_ERAL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == PG_ERAL) |=> (!org_i || rd_word_o == '1)); // R11
endmodule

// File: rtl/sprom_3w.sv
module sprom_3w
  import sprom_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WORDS       = 64,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o
);
  localparam int ADDR_W = $clog2(WORDS) + 1;

  logic cs_q, cs_d, sck_q, sck_d, di_q;
  logic sck_rise, cs_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      cs_d  <= 1'b0;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      di_q  <= 1'b0;
    end else begin
      cs_q  <= cs_i;
      cs_d  <= cs_q;
      sck_q <= sck_i;
      sck_d <= sck_q;
      di_q  <= di_i;
    end
  end

  assign sck_rise = sck_q && !sck_d;
  assign cs_fall  = !cs_q && cs_d;

  logic              start, busy, commit, dout;
  prog_op_e          dec_op, pg_op;
  logic [ADDR_W-1:0] dec_addr, pg_addr, rd_addr;
  logic [WORD_W-1:0] dec_data, pg_data, rd_word;

  sprom_decoder #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dec_i (
    .clk_i, .rst_ni,
    .cs_i(cs_q), .sck_rise_i(sck_rise), .cs_fall_i(cs_fall), .di_i(di_q),
    .org_i, .busy_i(busy), .rd_word_i(rd_word), .rd_addr_o(rd_addr),
    .dout_o(dout), .start_o(start), .op_o(dec_op), .addr_o(dec_addr), .data_o(dec_data)
  );

  sprom_prog_ctl #(.PROG_CYCLES(PROG_CYCLES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) pg_i (
    .clk_i, .rst_ni,
    .start_i(start), .op_i(dec_op), .addr_i(dec_addr), .data_i(dec_data),
    .busy_o(busy), .commit_o(commit), .op_o(pg_op), .addr_o(pg_addr), .data_o(pg_data)
  );

  sprom_array #(.WORD_W(WORD_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) arr_i (
    .clk_i, .rst_ni, .org_i,
    .commit_i(commit), .op_i(pg_op), .addr_i(pg_addr), .data_i(pg_data),
    .rd_addr_i(rd_addr), .rd_word_o(rd_word)
  );

  assign do_o = busy ? 1'b0 : dout;
endmodule

// File: tb/sprom_3w_tb_top.sv
module sprom_3w_tb_top;
  localparam int P = 200;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_i = 1'b0, sck_i = 1'b0, di_i = 1'b0, org_i = 1'b1;
  logic do_o;

  int checks = 0, errors = 0;
  logic [15:0] m [64];
  logic wen_m = 1'b0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sprom_3w #(.WORD_W(16), .WORDS(64), .PROG_CYCLES(P)) dut_i (
    .clk_i, .rst_ni, .cs_i, .sck_i, .di_i, .org_i, .do_o
  );

  function automatic int aw(); return org_i ? 6 : 7; endfunction
  function automatic int dw(); return org_i ? 16 : 8; endfunction

  function automatic logic [15:0] exp_word(input logic [6:0] a);
    if (org_i) return m[a[5:0]];
    return {8'h00, a[0] ? m[a[6:1]][15:8] : m[a[6:1]][7:0]};
  endfunction

  function automatic logic [6:0] inc(input logic [6:0] a);
    return org_i ? {1'b0, a[5:0] + 6'd1} : a + 7'd1;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk_i); endtask

  task automatic sck_bit(input logic b);
    di_i = b; tick(4); sck_i = 1'b1; tick(4); sck_i = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sck_bit(v[i]);
  endtask

  task automatic cs_on();  cs_i = 1'b1; tick(2); endtask
  task automatic cs_off(); cs_i = 1'b0; tick(2); endtask

  task automatic m_write(input logic [6:0] a, input logic [15:0] d);
    if (!wen_m) return;
    if (org_i) m[a[5:0]] = d;
    else if (a[0]) m[a[6:1]][15:8] = d[7:0];
    else m[a[6:1]][7:0] = d[7:0];
  endtask

  // write frame without waiting for the program cycle
  task automatic write_go(input logic [6:0] a, input logic [15:0] d);
    cs_on(); send(3'b101, 3); send(32'(a), aw()); send(32'(d), dw()); cs_off();
    m_write(a, d);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    write_go(a, d); tick(P + 2);
  endtask

  task automatic do_erase(input logic [6:0] a);
    cs_on(); send(3'b111, 3); send(32'(a), aw()); cs_off(); tick(P + 2);
    m_write(a, 16'hFFFF);
  endtask

  task automatic ext(input logic [1:0] sub, input logic [15:0] d);
    cs_on(); send(3'b100, 3); send(32'(sub) << (aw() - 2), aw());
    if (sub == 2'b01) send(32'(d), dw());
    cs_off(); tick(P + 2);
    if (sub == 2'b11) wen_m = 1'b1;
    if (sub == 2'b00) wen_m = 1'b0;
    if (wen_m && sub == 2'b10) for (int i = 0; i < 64; i++) m[i] = 16'hFFFF;
    if (wen_m && sub == 2'b01)
      for (int i = 0; i < 64; i++) m[i] = org_i ? d : {d[7:0], d[7:0]};
  endtask

  task automatic rd_chk(input logic [6:0] a, input int n, input int lz, input string tag);
    logic [15:0] got;
    logic [6:0] ca;
    cs_on();
    send(0, lz);
    send(3'b110, 3); send(32'(a), aw());
    chk({15'd0, do_o}, 16'd0, {tag, " R5 dummy bit"});
    ca = a;
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < dw(); b++) begin sck_bit(1'b0); got = {got[14:0], do_o}; end
      chk(got, exp_word(ca), tag);
      ca = inc(ca);
    end
    cs_off();
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [6:0] a;
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m[i] = 16'hFFFF;
    tick(3);
    chk({15'd0, do_o}, 16'd1, "R3 do_o high in reset");
    rst_ni = 1'b1; tick(2);
    chk({15'd0, do_o}, 16'd1, "R3 do_o high after reset");
    rd_chk(7'd0, 2, 0, "R3 erased array");

    // write-disabled after reset
    do_write(7'd5, 16'h1234);
    rd_chk(7'd5, 1, 0, "R7 write ignored when disabled");

    ext(2'b11, 16'h0);
    // busy window timing
    write_go(7'd10, 16'hA5A5);
    chk({15'd0, do_o}, 16'd0, "R8 busy at second clock");
    tick(P - 1);
    chk({15'd0, do_o}, 16'd0, "R8 busy at last clock");
    tick(1);
    chk({15'd0, do_o}, 16'd1, "R8 ready after PROG_CYCLES");
    rd_chk(7'd10, 1, 0, "R9 directed write");

    // frame cut short
    cs_on(); send(3'b101, 3); send(32'd11, 6); send(32'hF, 4); cs_off();
    chk({15'd0, do_o}, 16'd1, "R8 partial frame starts no cycle");
    tick(P);
    rd_chk(7'd11, 1, 0, "R8 partial frame leaves word");

    // frame during busy
    write_go(7'd20, 16'h1111);
    cs_on(); send(3'b111, 3); send(32'd10, 6); cs_off();
    chk({15'd0, do_o}, 16'd0, "R13 still busy after second frame");
    tick(P);
    rd_chk(7'd10, 1, 0, "R13 erase during busy ignored");
    rd_chk(7'd20, 1, 0, "R9 write before busy frame");

    for (int i = 0; i < 16; i++) begin
      a = 7'($urandom_range(0, 63));
      d = 16'($urandom);
      do_write(a, d);
      rd_chk(a, 1, 0, "R1 R9 random word write");
    end
    do_write(7'd63, 16'h0F0F);
    do_write(7'd62, 16'hBEEF);
    rd_chk(7'd62, 4, 0, "R6 sequential read wraps 63 to 0");
    rd_chk(7'd20, 1, 3, "R4 leading zeros ignored");
    do_erase(7'd62);
    rd_chk(7'd62, 1, 0, "R10 word erase");

    org_i = 1'b0; tick(2);
    for (int i = 0; i < 12; i++) begin
      a = 7'($urandom_range(0, 127));
      d = {8'h00, 8'($urandom)};
      do_write(a, d);
      rd_chk(a, 1, 0, "R2 random byte write");
    end
    do_write(7'd127, 16'h005A);
    do_write(7'd0, 16'h00C3);
    rd_chk(7'd126, 4, 0, "R6 byte read wraps 127 to 0");
    do_erase(7'd1);
    rd_chk(7'd0, 2, 0, "R10 byte erase");
    org_i = 1'b1; tick(2);
    rd_chk(7'd0, 1, 0, "R2 byte halves in word view");
    rd_chk(7'd63, 1, 0, "R2 top byte pair in word view");

    ext(2'b01, 16'h3C5A);
    rd_chk(7'd0, 3, 0, "R12 write-all words");
    org_i = 1'b0; tick(2);
    ext(2'b01, 16'h0096);
    rd_chk(7'd40, 2, 0, "R12 write-all bytes");
    org_i = 1'b1; tick(2);
    rd_chk(7'd20, 1, 0, "R12 byte fill in word view");
    ext(2'b10, 16'h0);
    rd_chk(7'd60, 4, 0, "R11 erase-all");

    do_write(7'd3, 16'h7777);
    ext(2'b00, 16'h0);
    do_write(7'd3, 16'h0000);
    rd_chk(7'd3, 1, 0, "R7 write after disable ignored");
    do_erase(7'd3);
    ext(2'b01, 16'h0000);
    rd_chk(7'd2, 2, 0, "R7 erase and write-all ignored");
    ext(2'b10, 16'h0);
    rd_chk(7'd3, 1, 0, "R7 erase-all ignored");

    finish_run();
  end
endmodule